// File: doc/BRIEF.md
# SPI Flash Sector Erase Responder

This block is the device-side command logic of a serial flash for erasing one sector. A host on a four-wire SPI bus lowers chip select and clocks bits in most significant first. The block accepts three commands: set the write-enable latch, erase a sector, and read the status byte. The erase is decided only when chip select goes high, and only if exactly opcode plus a 24-bit address were clocked in. The write-enable latch must be set, and the addressed sector must lie outside the block-protected range. The physical erase is represented by a busy timer whose length is a parameter in system clocks. When the timer expires, the block emits a one-cycle pulse carrying the sector index, which tells the array logic to clear that sector to all ones.

All SPI pins are oversampled by the system clock through synchronizers, so the host clock must be several times slower than the system clock. Both idle clock levels (mode 0 and mode 3) are accepted, because only rising serial-clock edges are counted. The status byte is driven out on falling serial-clock edges and always reflects the live state, so a host can poll the busy bit while an erase runs.

Top module: `sfe_responder`

## Requirements
- R1: After the read-status opcode 05h, SO presents the status byte MSB first, advancing on each falling SCK edge and repeating every 8 bits. Status bit 0 is write-in-progress, bit 1 is the write-enable latch, bits 4:2 equal `blockProtect[2:0]`, and bits 7:5 are 0. The SO enable is high only during this output phase; it is low during every other command and whenever chip select is high.
- R2: Opcode 06h followed by a chip-select rise after exactly 8 bits sets the write-enable latch.
- R3: Opcode D8h, followed by 24 address bits and a chip-select rise after exactly 32 bits, starts an erase when the latch is set and the sector is unprotected. A rise after any other bit count (for example 31 or 33) is discarded.
- R4: An erase issued while the write-enable latch is 0 does not start.
- R5: With `blockProtect` = k > 0, the top 2^(k-1) sectors are protected, and 7 protects all. An erase aimed at a protected sector does not start and leaves the write-enable latch unchanged.
- R6: Write-in-progress stays 1 for exactly ERASE_CYCLES clocks. Then `eraseDone` pulses for one cycle with `eraseSector` equal to address bits 21:16, the 64 KiB sector index; address bits 23:22 are ignored.
- R7: An accepted erase clears the write-enable latch in the same cycle that write-in-progress rises.
- R8: While write-in-progress is 1, only status reads act. A write-enable whose chip-select rise is evaluated in the cycle the timer expires is still ignored; one cycle later it is accepted.
- R9: Commands work with SCK idling low (mode 0) and idling high (mode 3).
- R10: After reset the status byte is 00h, the SO enable is low, and `eraseDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | SPI chip select, active low |
| spiSck | input | 1 | SPI serial clock from host |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial status data to host |
| spiMisoEn | output | 1 | Output enable for spiMiso (low means high impedance) |
| blockProtect | input | 3 | Block-protect level |
| eraseDone | output | 1 | One-cycle pulse when an erase finishes |
| eraseSector | output | SECTOR_BITS | Index of the erased sector, valid with eraseDone |

## Verification
The timer expiry and a chip-select rise that ends a write-enable command can land in the same system-clock cycle. The bench records the cycle in which it raised chip select for the erase. It then ends a write-enable frame exactly ERASE_CYCLES cycles later, so that the command decision and the busy clear share one clock. It repeats the pattern one cycle later. Each case is judged by a status read after the erase completes: the latch must read 0 in the coincident case and 1 in the late case. The scoreboard also checks the done pulse's sector and exact cycle.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;
  localparam logic [7:0] OP_WR_ENABLE    = 8'h06;
  localparam logic [7:0] OP_SECTOR_ERASE = 8'hD8;
  localparam logic [7:0] OP_READ_STATUS  = 8'h05;
  localparam int OPCODE_BITS    = 8;
  localparam int ERASE_FRAME    = 32;
  localparam int BIT_CNT_W      = 6;

  typedef struct packed {
    logic startBusy;
    logic startStatus;
  } ctlStrobes_t;
endpackage

// File: rtl/sfe_datapath.sv
`timescale 1ns/1ps
module sfe_datapath import sfe_pkg::*; #(
  parameter int SECTOR_BITS  = 6,
  parameter int SECTOR_SHIFT = 16,
  parameter int ERASE_CYCLES = 1000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   spiCsN,
  input  logic                   spiSck,
  input  logic                   spiMosi,
  input  ctlStrobes_t            ctl,
  input  logic [7:0]             statusByte,
  output logic                   opcodeDone,
  output logic                   csRise,
  output logic [7:0]             opcodeVal,
  output logic [BIT_CNT_W-1:0]   bitCount,
  output logic [SECTOR_BITS-1:0] sectorIdx,
  output logic                   busyDone,
  output logic                   spiMiso,
  output logic                   spiMisoEn
);
  localparam int TMR_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [BIT_CNT_W-1:0] LAST_OP_BIT = BIT_CNT_W'(OPCODE_BITS - 1);

  // pin synchronizers: {cs, sck, mosi}
  logic [2:0] syncPipe [SYNC_STAGES];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= 3'b100;
    end else begin
      syncPipe[0] <= {spiCsN, spiSck, spiMosi};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  logic csNow, sckNow, mosiNow, csPrev, sckPrev;
  assign csNow   = syncPipe[SYNC_STAGES-1][2];
  assign sckNow  = syncPipe[SYNC_STAGES-1][1];
  assign mosiNow = syncPipe[SYNC_STAGES-1][0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      csPrev  <= csNow;
      sckPrev <= sckNow;
    end
  end

  logic sckRise, sckFall, csFall;
  assign sckRise = !csNow && sckNow && !sckPrev;
  assign sckFall = !csNow && !sckNow && sckPrev;
  assign csRise  = csNow && !csPrev;
  assign csFall  = !csNow && csPrev;

  // input shifter and bit counter
  logic [ERASE_FRAME-1:0] shiftReg;
  logic [BIT_CNT_W-1:0]   bitCnt;
  logic [7:0]             opcodeReg;
  logic                   opcodeStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      opcodeReg <= '0;
      opcodeStb <= 1'b0;
    end else begin
      opcodeStb <= sckRise && (bitCnt == LAST_OP_BIT);
      if (csFall) begin
        bitCnt <= '0;
      end else if (sckRise && bitCnt != '1) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (sckRise) begin
        shiftReg <= {shiftReg[ERASE_FRAME-2:0], mosiNow};
        if (bitCnt == LAST_OP_BIT) opcodeReg <= {shiftReg[6:0], mosiNow};
      end
    end
  end

  assign opcodeDone = opcodeStb;
  assign opcodeVal  = opcodeReg;
  assign bitCount   = bitCnt;
  assign sectorIdx  = shiftReg[SECTOR_SHIFT +: SECTOR_BITS];

  // status output shifter
  logic       readActive;
  logic [2:0] outIdx;
  logic       misoReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readActive <= 1'b0;
      outIdx     <= 3'd7;
      misoReg    <= 1'b0;
    end else if (csRise) begin
      readActive <= 1'b0;
    end else if (ctl.startStatus) begin
      readActive <= 1'b1;
      outIdx     <= 3'd7;
      misoReg    <= 1'b0;
    end else if (readActive && sckFall) begin
      misoReg <= statusByte[outIdx];
      outIdx  <= outIdx - 3'd1;
    end
  end

  assign spiMiso   = misoReg;
  assign spiMisoEn = readActive;

  // erase busy timer
  logic [TMR_W-1:0] tmr;
  logic             tmrRun;
  assign busyDone = tmrRun && (tmr == TMR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr    <= '0;
      tmrRun <= 1'b0;
    end else if (ctl.startBusy) begin
      tmr    <= TMR_W'(ERASE_CYCLES);
      tmrRun <= 1'b1;
    end else if (tmrRun) begin
      tmr <= tmr - 1'b1;
      if (tmr == TMR_W'(1)) tmrRun <= 1'b0;
    end
  end
endmodule

// File: rtl/sfe_control.sv
`timescale 1ns/1ps
module sfe_control import sfe_pkg::*; #(
  parameter int SECTOR_BITS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   opcodeDone,
  input  logic                   csRise,
  input  logic [7:0]             opcodeVal,
  input  logic [BIT_CNT_W-1:0]   bitCount,
  input  logic [SECTOR_BITS-1:0] sectorIdx,
  input  logic                   busyDone,
  input  logic [2:0]             blockProtect,
  output ctlStrobes_t            ctl,
  output logic [7:0]             statusByte,
  output logic                   eraseDone,
  output logic [SECTOR_BITS-1:0] eraseSector,
  output logic                   welState,
  output logic                   wipState
);
  localparam int PW = SECTOR_BITS + 1;
  localparam logic [PW-1:0] ALL_SECTORS = PW'(2 ** SECTOR_BITS);

  // protected range: top 2^(k-1) sectors, saturating at all of them
  logic [PW-1:0] protCount;
  logic          sectorLocked;
  always_comb begin
    if (blockProtect == 3'd0)
      protCount = '0;
    else if (int'(blockProtect) - 1 >= SECTOR_BITS)
      protCount = ALL_SECTORS;
    else
      protCount = PW'(1) << (blockProtect - 3'd1);
    sectorLocked = (protCount != '0) && ({1'b0, sectorIdx} >= (ALL_SECTORS - protCount));
  end

  logic eraseGo, welSet;
  assign eraseGo = csRise && !wipState && (opcodeVal == OP_SECTOR_ERASE)
                && (bitCount == BIT_CNT_W'(ERASE_FRAME)) && welState && !sectorLocked;
  assign welSet  = csRise && !wipState && (opcodeVal == OP_WR_ENABLE)
                && (bitCount == BIT_CNT_W'(OPCODE_BITS));

  assign ctl.startBusy   = eraseGo;
  assign ctl.startStatus = opcodeDone && (opcodeVal == OP_READ_STATUS);
  assign statusByte      = {3'b000, blockProtect, welState, wipState};

  logic [SECTOR_BITS-1:0] pendSector;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welState    <= 1'b0;
      wipState    <= 1'b0;
      pendSector  <= '0;
      eraseDone   <= 1'b0;
      eraseSector <= '0;
    end else begin
      eraseDone <= busyDone;
      if (eraseGo) begin
        welState   <= 1'b0;
        wipState   <= 1'b1;
        pendSector <= sectorIdx;
      end else begin
        if (welSet)   welState <= 1'b1;
        if (busyDone) wipState <= 1'b0;
      end
      if (busyDone) eraseSector <= pendSector;
    end
  end
endmodule

// File: rtl/sfe_responder.sv
`timescale 1ns/1ps
module sfe_responder import sfe_pkg::*; #(
  parameter int SECTOR_COUNT = 64,
  parameter int SECTOR_SHIFT = 16,
  parameter int ERASE_CYCLES = 1000000,
  parameter int SYNC_STAGES  = 2,
  localparam int SECTOR_BITS = $clog2(SECTOR_COUNT)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   spiCsN,
  input  logic                   spiSck,
  input  logic                   spiMosi,
  output logic                   spiMiso,
  output logic                   spiMisoEn,
  input  logic [2:0]             blockProtect,
  output logic                   eraseDone,
  output logic [SECTOR_BITS-1:0] eraseSector
);
  ctlStrobes_t            ctl;
  logic [7:0]             statusByte, opcodeVal;
  logic                   opcodeDone, csRise, busyDone, welState, wipState;
  logic [BIT_CNT_W-1:0]   bitCount;
  logic [SECTOR_BITS-1:0] sectorIdx;

  sfe_datapath #(
    .SECTOR_BITS(SECTOR_BITS), .SECTOR_SHIFT(SECTOR_SHIFT),
    .ERASE_CYCLES(ERASE_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi),
    .ctl(ctl), .statusByte(statusByte), .opcodeDone(opcodeDone), .csRise(csRise),
    .opcodeVal(opcodeVal), .bitCount(bitCount), .sectorIdx(sectorIdx),
    .busyDone(busyDone), .spiMiso(spiMiso), .spiMisoEn(spiMisoEn)
  );

  sfe_control #(.SECTOR_BITS(SECTOR_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .opcodeDone(opcodeDone), .csRise(csRise),
    .opcodeVal(opcodeVal), .bitCount(bitCount), .sectorIdx(sectorIdx),
    .busyDone(busyDone), .blockProtect(blockProtect), .ctl(ctl),
    .statusByte(statusByte), .eraseDone(eraseDone), .eraseSector(eraseSector),
    .welState(welState), .wipState(wipState)
  );
endmodule

// File: rtl/sfe_checker.sv
`timescale 1ns/1ps
module sfe_checker (
  input logic clk,
  input logic rstN,
  input logic spiCsN,
  input logic spiMisoEn,
  input logic eraseDone,
  input logic welState,
  input logic wipState
);
  AST_SO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (spiCsN && $past(spiCsN) && $past(spiCsN, 2) && $past(spiCsN, 3)) |-> !spiMisoEn); // R1
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wipState) |-> $past(welState)); // R4
  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    eraseDone |=> !eraseDone); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    eraseDone |-> (!wipState && $past(wipState))); // R6
  AST_START_DROPS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wipState) |-> !welState); // R7
  AST_NO_WEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wipState |-> !welState); // R8
endmodule

bind sfe_responder sfe_checker u_sfe_checker (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiMisoEn(spiMisoEn),
  .eraseDone(eraseDone), .welState(welState), .wipState(wipState)
);

// File: tb/sfe_responder_bench.sv
`timescale 1ns/1ps
module sfe_responder_bench;
  localparam int N = 2000;
  localparam int H = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0, spiCsN = 1'b1, spiSck = 1'b0, spiMosi = 1'b0;
  logic [2:0] blockProtect = 3'd0;
  logic       spiMiso, spiMisoEn, eraseDone;
  logic [5:0] eraseSector;

  sfe_responder #(.ERASE_CYCLES(N)) u_sfe_responder (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiMisoEn(spiMisoEn), .blockProtect(blockProtect),
    .eraseDone(eraseDone), .eraseSector(eraseSector)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit mode3 = 1'b0;
  bit soSeen;
  int unsigned lastRise;

  typedef struct { int sector; int unsigned when; } expItem_t;
  expItem_t expQ[$];
  expItem_t got;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferBit(input bit b, output bit s, output bit en);
    spiSck = 1'b0;
    spiMosi = b;
    waitCyc(H);
    s = spiMiso;
    en = spiMisoEn;
    if (spiMisoEn) soSeen = 1'b1;
    spiSck = 1'b1;
    waitCyc(H);
    if (!mode3) spiSck = 1'b0;
  endtask

  task automatic startFrame();
    @(negedge clk);
    spiSck = mode3;
    spiCsN = 1'b0;
    soSeen = 1'b0;
    waitCyc(H);
  endtask

  task automatic shiftBits(input logic [39:0] data, input int n);
    bit s, en;
    for (int i = n - 1; i >= 0; i--) xferBit(data[i], s, en);
  endtask

  task automatic endFrame();
    waitCyc(H);
    spiCsN = 1'b1;
    lastRise = cyc;
    waitCyc(3 * H);
  endtask

  task automatic wrEnable();
    startFrame(); shiftBits(40'h06, 8); endFrame();
  endtask

  // erase command; nbits 31/32/33 truncates or extends the frame
  task automatic eraseCmd(input logic [23:0] addr, input int nbits, input bit expectGo);
    logic [39:0] d;
    expItem_t it;
    d = {16'h0, 8'hD8, addr};
    if (nbits == 33) d = d << 1;
    if (nbits == 31) d = d >> 1;
    startFrame(); shiftBits(d, nbits); endFrame();
    check("R1", int'(soSeen), 0, "SO enable during erase command");
    if (expectGo) begin
      it.sector = int'(addr[21:16]);
      it.when = lastRise + N + 3;
      expQ.push_back(it);
    end
  endtask

  task automatic readStatus(input string req, input int exp);
    bit s, en, allEn;
    logic [15:0] rx;
    startFrame(); shiftBits(40'h05, 8);
    allEn = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      xferBit(1'b0, s, en);
      rx[i] = s;
      allEn &= en;
    end
    endFrame();
    check(req, int'(rx[15:8]), exp, "status byte");
    check("R1", int'(rx[7:0]), exp, "repeated status byte");
    check("R1", int'(allEn), 1, "SO enable during status output");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && eraseDone) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected erase done sector actual=%0d expected=none", eraseSector);
      end else begin
        got = expQ.pop_front();
        if (int'(eraseSector) != got.sector || cyc != got.when) begin
          errors++;
          $display("FAIL R6 erase done actual=sector %0d cycle %0d expected=sector %0d cycle %0d",
                   eraseSector, cyc, got.sector, got.when);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);
    check("R10", int'(spiMisoEn), 0, "SO enable after reset");
    check("R10", int'(eraseDone), 0, "done after reset");
    readStatus("R10", 8'h00);

    wrEnable();
    readStatus("R2", 8'h02);

    eraseCmd(24'h05ABCD, 31, 1'b0);
    eraseCmd(24'h05ABCD, 33, 1'b0);
    waitCyc(N + 20);
    readStatus("R3", 8'h02);

    eraseCmd(24'h05ABCD, 32, 1'b1);
    readStatus("R7", 8'h01);
    waitCyc(N);
    readStatus("R6", 8'h00);

    eraseCmd(24'h070000, 32, 1'b0);
    waitCyc(N + 20);
    readStatus("R4", 8'h00);

    blockProtect = 3'd2;
    wrEnable();
    readStatus("R5", 8'h0A);
    eraseCmd(24'h3E0000, 32, 1'b0);
    waitCyc(N + 20);
    readStatus("R5", 8'h0A);
    eraseCmd(24'h3D1234, 32, 1'b1);
    readStatus("R5", 8'h09);
    waitCyc(N);
    blockProtect = 3'd7;
    wrEnable();
    eraseCmd(24'h000000, 32, 1'b0);
    waitCyc(N + 20);
    readStatus("R5", 8'h1E);
    blockProtect = 3'd0;

    mode3 = 1'b1;
    readStatus("R9", 8'h02);
    eraseCmd(24'hFF0010, 32, 1'b1);
    readStatus("R9", 8'h01);
    waitCyc(N);
    wrEnable();
    readStatus("R9", 8'h02);
    mode3 = 1'b0;

    // busy: write enable ignored, then coincident with expiry
    begin
      int unsigned t0;
      eraseCmd(24'h010000, 32, 1'b1);
      t0 = lastRise;
      wrEnable();
      readStatus("R8", 8'h01);
      startFrame(); shiftBits(40'h06, 8);
      while (cyc != t0 + N) @(negedge clk);
      spiCsN = 1'b1;
      waitCyc(N);
      readStatus("R8", 8'h00);

      wrEnable();
      eraseCmd(24'h020000, 32, 1'b1);
      t0 = lastRise;
      startFrame(); shiftBits(40'h06, 8);
      while (cyc != t0 + N + 1) @(negedge clk);
      spiCsN = 1'b1;
      waitCyc(N);
      readStatus("R8", 8'h02);
    end

    waitCyc(20);
    check("R6", expQ.size(), 0, "outstanding erase completions");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule